// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is a single input port that takes bytes from a peripheral under a two-wire handshake. The peripheral waits until the buffer-full flag is low. It then drives a byte and pulses an active-low strobe. On the rising edge of that strobe the port captures the byte, raises the buffer-full flag, and raises an interrupt request if interrupts are enabled. A processor data read returns the captured byte and empties the buffer, which drops both flags.

With interrupts disabled the port still fills. Software then learns of a full buffer by reading a status byte, which carries the buffer-full, interrupt-enable and interrupt-request bits. The strobe is asynchronous to the processor clock, so it passes through a parameterised synchroniser before its rising edge is detected.

Top module: `strobe_in_port`

## Requirements
- R1: A synchronous reset (`rst` high) clears the buffer-full flag, the interrupt request, the interrupt enable and the held byte to 0. After reset the data read and the status read both return 0.
- R2: A low-to-high transition of `per_stb_n` is acted on at the (SYNC_STAGES+1)-th rising clock edge after the transition. At that edge `per_data` is captured and `per_ibf` goes to 1. Before that edge `per_ibf` is still 0.
- R3: The byte is held, not passed through. The data read returns the last captured byte whatever `per_data` does before or after a capture.
- R4: If the interrupt enable is 1 at the capture edge, `cpu_intr` goes to 1 at the same edge as `per_ibf`.
- R5: If the interrupt enable is 0, a capture still sets `per_ibf`, but `cpu_intr` stays 0 and only the status byte shows the full buffer.
- R6: A data read (`cpu_rd`=1 with `cpu_sel`=0) shows the held byte on `cpu_dout` in the same cycle. It clears `per_ibf` and `cpu_intr` at that clock edge.
- R7: With `cpu_sel`=1, `cpu_dout` is the status byte: bit 3 is the interrupt request, bit 4 is the interrupt enable, bit 5 is buffer-full, and all other bits are 0. A status read (`cpu_rd`=1, `cpu_sel`=1) clears nothing.
- R8: A strobe rising edge that arrives while `per_ibf` is 1 is ignored. The held byte and the flags keep their values.
- R9: A command cycle (`inte_wr`=1) loads `inte_set` into the interrupt enable at that edge. Clearing the enable while `cpu_intr` is 1 drops `cpu_intr` at the same edge and leaves `per_ibf` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor-side clock |
| rst | input | 1 | Synchronous reset, active high |
| per_data | input | DATA_W | Byte driven by the peripheral |
| per_stb_n | input | 1 | Peripheral strobe, active low, asynchronous |
| per_ibf | output | 1 | Buffer-full flag to the peripheral |
| cpu_rd | input | 1 | Processor read cycle, one clock per access |
| cpu_sel | input | 1 | Read select: 0 = held byte, 1 = status byte |
| inte_wr | input | 1 | Interrupt-enable command strobe |
| inte_set | input | 1 | Value written to the interrupt enable |
| cpu_dout | output | DATA_W | Read data, combinational from `cpu_sel` |
| cpu_intr | output | 1 | Interrupt request to the processor |

## Verification
The strobe result is due SYNC_STAGES+1 clock edges after `per_stb_n` rises. The bench derives that figure from the parameter and checks `per_ibf` one edge early (still 0) and again on time (now 1). Read data is combinational, so it is compared in the same cycle the select is driven. A data read's clearing effect and an enable command's effect land one edge later, and the bench expects them there. Every expectation is queued at a falling edge and compared a quarter period later, before the next rising edge can move the outputs.

// File: rtl/sip_pkg.sv
package sip_pkg;

  localparam int STAT_W        = 8;
  localparam int STAT_INTR_BIT = 3;
  localparam int STAT_INTE_BIT = 4;
  localparam int STAT_IBF_BIT  = 5;

  typedef enum logic {
    SEL_DATA   = 1'b0,
    SEL_STATUS = 1'b1
  } rd_sel_e;

  // Assemble the status byte from the three flags.
  function automatic logic [STAT_W-1:0] status_byte(input logic ibf,
                                                    input logic inte,
                                                    input logic intr);
    logic [STAT_W-1:0] s;
    s = '0;
    s[STAT_IBF_BIT]  = ibf;
    s[STAT_INTE_BIT] = inte;
    s[STAT_INTR_BIT] = intr;
    return s;
  endfunction

endpackage

// File: rtl/sip_strobe_sync.sv
module sip_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stb_n,
  output logic rise
);
  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  // Idle level of the strobe is high, so every stage resets to 1.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= 1'b1;
          else     stage_q[0] <= stb_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[i] <= 1'b1;
          else     stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= stage_q[STAGES-1];
  end

  assign rise = stage_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sip_latch.sv
module sip_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/sip_flags.sv
module sip_flags (
  input  logic clk,
  input  logic rst,
  input  logic cap_evt,
  input  logic rd_clr,
  input  logic inte_wr,
  input  logic inte_set,
  output logic ibf,
  output logic intr,
  output logic inte
);
  logic inte_off;
  assign inte_off = inte_wr & ~inte_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      ibf  <= 1'b0;
      intr <= 1'b0;
      inte <= 1'b0;
    end else begin
      if (inte_wr) inte <= inte_set;

      // A capture only happens on an empty buffer, so it outranks a read.
      if (cap_evt)     ibf <= 1'b1;
      else if (rd_clr) ibf <= 1'b0;

      // Disabling outranks everything, which keeps intr inside inte.
      if (inte_off)              intr <= 1'b0;
      else if (cap_evt && inte)  intr <= 1'b1;
      else if (rd_clr)           intr <= 1'b0;
    end
  end
endmodule

// File: rtl/strobe_in_port.sv
module strobe_in_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] per_data,
  input  logic              per_stb_n,
  output logic              per_ibf,
  input  logic              cpu_rd,
  input  logic              cpu_sel,
  input  logic              inte_wr,
  input  logic              inte_set,
  output logic [DATA_W-1:0] cpu_dout,
  output logic              cpu_intr
);
  import sip_pkg::*;

  localparam int STROBE_LATENCY = SYNC_STAGES + 1;

  logic              stb_rise;
  logic              cap_evt;
  logic              rd_clr;
  logic              ibf;
  logic              intr;
  logic              inte;
  logic [DATA_W-1:0] data_q;
  logic [STAT_W-1:0] stat;

  sip_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .stb_n (per_stb_n),
    .rise  (stb_rise)
  );

  // Named events for the checker.
  assign cap_evt = stb_rise & ~ibf;
  assign rd_clr  = cpu_rd & (rd_sel_e'(cpu_sel) == SEL_DATA);

  sip_latch #(.W(DATA_W)) u_latch (
    .clk  (clk),
    .rst  (rst),
    .load (cap_evt),
    .din  (per_data),
    .q    (data_q)
  );

  sip_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .cap_evt  (cap_evt),
    .rd_clr   (rd_clr),
    .inte_wr  (inte_wr),
    .inte_set (inte_set),
    .ibf      (ibf),
    .intr     (intr),
    .inte     (inte)
  );

  assign stat     = status_byte(ibf, inte, intr);
  assign cpu_dout = (rd_sel_e'(cpu_sel) == SEL_STATUS) ? DATA_W'(stat) : data_q;
  assign per_ibf  = ibf;
  assign cpu_intr = intr;

  if (STROBE_LATENCY < 2 || DATA_W < STAT_W) begin : g_bad_param
    initial $error("strobe_in_port: SYNC_STAGES must be >= 1 and DATA_W >= 8");
  end
endmodule

// File: rtl/sip_checker.sv
module sip_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cap_evt,
  input logic         rd_clr,
  input logic         ibf,
  input logic         intr,
  input logic         inte,
  input logic [W-1:0] data_q
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!ibf && !intr && !inte && data_q == '0));

  a_r2_capture_sets_ibf: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> ibf);

  a_r4_intr_with_capture: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && inte) |=> intr);

  a_r4_intr_needs_ibf: assert property (@(posedge clk) disable iff (rst)
    intr |-> ibf);

  a_r5_intr_needs_inte: assert property (@(posedge clk) disable iff (rst)
    intr |-> inte);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !cap_evt) |=> (!ibf && !intr));

  a_r8_full_holds_data: assert property (@(posedge clk) disable iff (rst)
    (ibf && !rd_clr) |=> (ibf && $stable(data_q)));
endmodule

bind strobe_in_port sip_checker #(.W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cap_evt (cap_evt),
  .rd_clr  (rd_clr),
  .ibf     (ibf),
  .intr    (intr),
  .inte    (inte),
  .data_q  (data_q)
);

// File: tb/strobe_in_port_test.sv
module strobe_in_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int LAT        = SYNC + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] per_data = '0;
  logic       per_stb_n = 1'b1;
  logic       per_ibf;
  logic       cpu_rd = 1'b0;
  logic       cpu_sel = 1'b0;
  logic       inte_wr = 1'b0;
  logic       inte_set = 1'b0;
  logic [7:0] cpu_dout;
  logic       cpu_intr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct packed {
    logic [1:0] kind;  // 0 dout, 1 ibf, 2 intr
    logic [7:0] req;
    logic [7:0] val;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_in_port #(.DATA_W(8), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .per_data(per_data), .per_stb_n(per_stb_n),
    .per_ibf(per_ibf), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel),
    .inte_wr(inte_wr), .inte_set(inte_set), .cpu_dout(cpu_dout),
    .cpu_intr(cpu_intr)
  );

  // Monitor: compares queued items a quarter period after each falling edge.
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    while (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      case (it.kind)
        2'd0:    act = cpu_dout;
        2'd1:    act = {7'b0, per_ibf};
        default: act = {7'b0, cpu_intr};
      endcase
      checks++;
      if (act !== it.val) begin
        fails++;
        $display("FAIL R%0d kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.val);
      end
    end
  end

  // Status byte restated: intr at bit 3, inte at bit 4, ibf at bit 5.
  function automatic logic [7:0] stat(input bit ibf, input bit inte, input bit intr);
    return (ibf ? 8'h20 : 8'h00) | (inte ? 8'h10 : 8'h00) | (intr ? 8'h08 : 8'h00);
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_item(input int kind, input logic [7:0] val, input int req);
    item_t it;
    it.kind = kind[1:0];
    it.req  = req[7:0];
    it.val  = val;
    sb.push_back(it);
  endtask

  task automatic expect_flags(input bit ibf, input bit intr, input int req);
    expect_item(1, {7'b0, ibf}, req);
    expect_item(2, {7'b0, intr}, req);
  endtask

  task automatic expect_data(input logic [7:0] d, input int req);
    cpu_sel = 1'b0;
    expect_item(0, d, req);
  endtask

  task automatic expect_status(input logic [7:0] s, input int req);
    cpu_sel = 1'b1;
    expect_item(0, s, req);
  endtask

  task automatic set_inte(input bit v);
    inte_wr = 1'b1; inte_set = v;
    tick(1);
    inte_wr = 1'b0;
  endtask

  // Strobe pulse; returns at the falling edge where the capture is visible.
  task automatic strobe(input logic [7:0] d);
    per_data  = d;
    per_stb_n = 1'b0;
    tick(LAT);
    per_stb_n = 1'b1;
    tick(LAT);
  endtask

  task automatic data_read(input logic [7:0] d, input int req);
    cpu_sel = 1'b0; cpu_rd = 1'b1;
    expect_item(0, d, req);
    tick(1);
    cpu_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    // R1: reset state
    expect_flags(0, 0, 1);
    expect_status(8'h00, 1);
    tick(1);
    expect_data(8'h00, 1);
    tick(1);

    // R9: enable interrupts
    set_inte(1);
    expect_status(stat(0, 1, 0), 9);
    tick(1);

    // R2 / R3: capture timing, data not transparent while strobe low
    per_data = 8'hA5; per_stb_n = 1'b0;
    expect_data(8'h00, 3);
    tick(LAT);
    per_stb_n = 1'b1;
    tick(LAT - 1);
    expect_flags(0, 0, 2);            // R2: one edge early, still empty
    tick(1);
    expect_flags(1, 1, 4);            // R4: intr with ibf
    expect_data(8'hA5, 2);
    tick(1);

    // R7: status read clears nothing
    cpu_sel = 1'b1; cpu_rd = 1'b1;
    expect_item(0, stat(1, 1, 1), 7);
    tick(1);
    cpu_rd = 1'b0;
    expect_flags(1, 1, 7);
    tick(1);

    // R8 / R3: strobe while full is ignored, held byte kept
    strobe(8'h3C);
    expect_flags(1, 1, 8);
    expect_data(8'hA5, 8);
    tick(1);

    // R6: data read returns byte and clears both flags
    data_read(8'hA5, 6);
    expect_flags(0, 0, 6);
    expect_status(stat(0, 1, 0), 6);
    tick(1);

    // R5: interrupts disabled, polling via status
    set_inte(0);
    strobe(8'h5A);
    expect_flags(1, 0, 5);
    expect_status(stat(1, 0, 0), 5);
    tick(1);
    data_read(8'h5A, 5);
    expect_flags(0, 0, 5);
    tick(1);

    // R9: clearing enable drops a pending request, buffer stays full
    set_inte(1);
    strobe(8'hC3);
    expect_flags(1, 1, 9);
    tick(1);
    set_inte(0);
    expect_flags(1, 0, 9);
    expect_status(stat(1, 0, 0), 9);
    tick(1);
    data_read(8'hC3, 9);
    expect_flags(0, 0, 9);
    tick(1);

    // R3: extreme patterns, input changed after capture
    strobe(8'hFF);
    per_data = 8'h00;
    tick(1);
    expect_data(8'hFF, 3);
    tick(1);
    data_read(8'hFF, 3);
    strobe(8'h00);
    per_data = 8'h81;
    expect_flags(1, 0, 3);
    tick(1);
    data_read(8'h00, 3);
    expect_flags(0, 0, 6);
    tick(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule